// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a word-wide data stream by a fixed number of clock cycles. It does not pass the words through a chain of flip-flops. It writes each incoming word into a two-port register array and reads the word stored one pass earlier. Only the two addresses move; a stored word stays where it was written until the write address comes round to it again.

A write address counter and a read address counter advance together on every clock. Synchronous reset loads the read counter with zero and the write counter with the highest address, so the write address always sits one entry behind the read address. Incoming words go through one capture register before the array. With the registered read port, the output is the input delayed by exactly `DEPTH` cycles.

An output-valid flag stays low until the array holds a full pass of words written since reset. An optional masking variant, selected by a parameter, forces the data output to zero while the flag is low. `DEPTH` must be a power of two of at least 2, and elaboration rejects any other value.

Top module: `ram_delay_line`

## Requirements
- R1: While synchronous reset is applied, `valid_o` reads 0 and `dout_o` reads all zeros after the next rising edge.
- R2: Count the rising edges after reset is released as edge 0, 1, 2 and so on. `valid_o` stays 0 through edge `DEPTH-1` and becomes 1 after edge `DEPTH`. Once high, it remains high until the next reset.
- R3: When `valid_o` is 1, `dout_o` after edge m+`DEPTH` equals the `din_i` value sampled at edge m. The delay is exactly `DEPTH` cycles.
- R4: Every one of the 2^`WIDTH` word values passes through unaltered in every bit position.
- R5: The fixed delay holds over many wraps of the addresses and for any data pattern, including alternating and complementary words.
- R6: Applying reset in the middle of a stream restarts the fill. After the first reset edge `valid_o` is 0. Afterwards the only words that appear while `valid_o` is 1 are words presented after reset was released.
- R7: With `MASK_INVALID` = 1 (the default), `dout_o` reads all zeros in every cycle in which `valid_o` is 0.
- R8: The read address starts at 0 and the write address at `DEPTH-1`. Each advances by one, modulo `DEPTH`, on every clock that is not a reset clock, so the write address always trails the read address by one entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | WIDTH | Data word sampled on every rising edge |
| dout_o | output | WIDTH | Data word presented `DEPTH` cycles earlier |
| valid_o | output | 1 | High once `dout_o` carries data written since reset |

## Verification
A wrong start value or a wrong step in either address counter breaks the one-entry gap between them. The delay then changes length, and the first cycle in which `valid_o` is high already shows a word from the wrong cycle. At the latest, the error shows within one pass of `DEPTH` cycles. A fault in the fill counter moves the rising edge of `valid_o`. An early rise shows up at once as zeros or stale words at the output, and a late rise shows up as a cycle-exact mismatch of the flag. A corrupted data bit or a swapped address bit shows up in the sweep over all word values within one pass after it first occurs.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

   // Legal depths are powers of two no smaller than two.
   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // Address width for a given depth, never below one bit.
   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/rdl_ptr.sv
module rdl_ptr #(
   parameter int unsigned   AW    = 4,
   parameter logic [AW-1:0] START = '0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   output logic [AW-1:0] ptr_o
);

   // Free-running address; wraps naturally at 2**AW.
   always_ff @(posedge clk_i) begin
      if (rst_i) ptr_o <= START;
      else       ptr_o <= ptr_o + AW'(1);
   end

endmodule

// File: rtl/rdl_store.sv
module rdl_store #(
   parameter int unsigned W  = 8,
   parameter int unsigned D  = 16,
   parameter int unsigned AW = 4
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [W-1:0]  wr_data_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [W-1:0]  rd_data_o
);

   logic [W-1:0] mem [D];

   // Write port: one word every cycle, no enable.
   always_ff @(posedge clk_i) begin
      mem[wr_addr_i] <= wr_data_i;
   end

   // Read port: registered, returns the contents before this edge's write.
   always_ff @(posedge clk_i) begin
      if (rst_i) rd_data_o <= '0;
      else       rd_data_o <= mem[rd_addr_i];
   end

endmodule

// File: rtl/rdl_fill.sv
module rdl_fill #(
   parameter int unsigned D  = 16,
   parameter int unsigned CW = 5
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic valid_o
);

   logic [CW-1:0] cnt;

   // Count edges since reset; the flag sets on the edge where D were seen.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt     <= '0;
         valid_o <= 1'b0;
      end else begin
         if (!valid_o) cnt <= cnt + CW'(1);
         valid_o <= valid_o | (cnt == CW'(D));
      end
   end

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
   parameter int unsigned WIDTH        = 8,
   parameter int unsigned DEPTH        = 16,
   parameter bit          MASK_INVALID = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] dout_o,
   output logic             valid_o
);

   localparam int unsigned AW = rdl_pkg::addr_bits(DEPTH);
   localparam int unsigned CW = AW + 1;

   // Elaboration-time parameter checks.
   generate
      if (!rdl_pkg::is_pow2(DEPTH)) begin : g_bad_depth
         $error("ram_delay_line: DEPTH must be a power of two of at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ram_delay_line: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] din_q;
   logic [WIDTH-1:0] rd_word;
   logic [AW-1:0]    rd_ptr;
   logic [AW-1:0]    wr_ptr;

   // Input capture stage ahead of the array write port.
   always_ff @(posedge clk_i) begin
      if (rst_i) din_q <= '0;
      else       din_q <= din_i;
   end

   rdl_ptr #(.AW(AW), .START({AW{1'b0}})) u_rd_ptr (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .ptr_o (rd_ptr)
   );

   rdl_ptr #(.AW(AW), .START({AW{1'b1}})) u_wr_ptr (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .ptr_o (wr_ptr)
   );

   rdl_store #(.W(WIDTH), .D(DEPTH), .AW(AW)) u_store (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .wr_addr_i (wr_ptr),
      .wr_data_i (din_q),
      .rd_addr_i (rd_ptr),
      .rd_data_o (rd_word)
   );

   rdl_fill #(.D(DEPTH), .CW(CW)) u_fill (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .valid_o (valid_o)
   );

   // Output variant: gate stale words to zero, or pass the read port through.
   generate
      if (MASK_INVALID) begin : g_masked
         assign dout_o = valid_o ? rd_word : '0;
      end else begin : g_raw
         assign dout_o = rd_word;
      end
   endgenerate

endmodule

// File: rtl/rdl_checker.sv
module rdl_checker #(
   parameter int unsigned AW = 4
) (
   input logic          clk,
   input logic          rst,
   input logic          valid,
   input logic [AW-1:0] rd_ptr,
   input logic [AW-1:0] wr_ptr
);

   // R1
   reset_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !valid);

   // R2
   valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
      valid |=> valid);

   // R2
   valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(valid) |-> (rd_ptr == AW'(1)));

   // R8
   ptr_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_ptr + AW'(1)) == rd_ptr);

   // R8
   rd_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (rd_ptr == $past(rd_ptr) + AW'(1)));

   // R8
   reset_start_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (rd_ptr == '0) && (wr_ptr == {AW{1'b1}}));

endmodule

bind ram_delay_line rdl_checker #(.AW(AW)) u_chk (
   .clk    (clk_i),
   .rst    (rst_i),
   .valid  (valid_o),
   .rd_ptr (rd_ptr),
   .wr_ptr (wr_ptr)
);

// File: tb/ram_delay_line_tb.sv
`timescale 1ns/1ps
module ram_delay_line_tb;

   localparam int unsigned W = 8;
   localparam int unsigned D = 8;
   localparam int unsigned HN = 1024;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout;
   logic         valid;

   int checks = 0;
   int fails  = 0;
   int n      = 0;
   bit done   = 1'b0;
   logic [W-1:0] hist [HN];

   always #2 clk = ~clk;   // 250 MHz

   ram_delay_line #(.WIDTH(W), .DEPTH(D), .MASK_INVALID(1'b1)) u_dut (
      .clk_i   (clk),
      .rst_i   (rst),
      .din_i   (din),
      .dout_o  (dout),
      .valid_o (valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, n);
      end
   endtask

   // Compare both outputs against values derived from the recorded inputs.
   task automatic check_outputs(input string tag);
      bit           ev;
      logic [W-1:0] ed;
      ev = (n >= D + 1);
      ed = ev ? hist[n - 1 - D] : '0;
      check(valid === ev, "R2 valid timing", int'(valid), int'(ev));
      if (ev) check(dout === ed, tag, int'(dout), int'(ed));
      else    check(dout === '0, "R7 masked output", int'(dout), 0);
   endtask

   // Drive one word, let one edge pass, check after it.
   task automatic tick(input logic [W-1:0] d, input string tag);
      din = d;
      hist[n] = d;
      @(posedge clk);
      n++;
      @(negedge clk);
      check_outputs(tag);
   endtask

   task automatic do_reset(input int cycles);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      // R6: the flag and the masked output drop after the first reset edge
      check(valid === 1'b0, "R6 valid after reset", int'(valid), 0);
      check(dout === '0, "R6 dout after reset", int'(dout), 0);
      for (int i = 1; i < cycles; i++) @(negedge clk);
      rst = 1'b0;
      n = 0;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(valid === 1'b0, "R1 valid in reset", int'(valid), 0);
      check(dout === '0, "R1 dout in reset", int'(dout), 0);
      rst = 1'b0;
      n = 0;

      // R3 R4 R8: every word value, counting pattern over several wraps
      for (int i = 0; i < 300; i++) tick(W'(i), "R3 R4 R8 data");

      // R6: reset mid-stream, then a scrambled pattern
      do_reset(2);
      for (int i = 0; i < 200; i++) tick(W'(i * 37 + 11), "R6 R5 data after restart");

      // R6: reset while the array is only partly refilled
      do_reset(1);
      for (int i = 0; i < 5; i++) tick(W'(8'hC3 + i), "R6 partial fill");
      do_reset(3);

      // R5: alternating and complementary words over many wraps
      for (int i = 0; i < 160; i++) begin
         logic [W-1:0] v;
         case (i % 4)
            0: v = 8'hAA;
            1: v = 8'h55;
            2: v = 8'h00;
            default: v = 8'hFF;
         endcase
         tick(v, "R5 alternating data");
      end

      // R5: walking one with inversion every other pass
      for (int i = 0; i < 64; i++) begin
         logic [W-1:0] v;
         v = W'(1) << (i % W);
         if ((i / W) % 2 == 1) v = ~v;
         tick(v, "R5 walking data");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule